// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller collects up to 64 interrupt sources, holds a pending flag per source, and picks one source to present to the processor. Software reaches it over a simple 32-bit register bus with a select, a write strobe, a byte address and read data that is valid in the same cycle as the address. Each source has a pending flag, an enable bit, a 5-bit priority field and a 32-bit vector offset word. Most registers also answer at two alias addresses. One alias clears the bits written as 1 and the other sets them, so software never needs a read-modify-write sequence.

Sources come in three kinds, fixed by parameters. Persistent sources follow a level: their flag stays set while the input is high and cannot be cleared until the input goes low. Ordinary event sources set their flag on a rising input edge. The lowest-numbered sources are external pins whose active edge is chosen in the control register. Among the enabled, pending sources with a nonzero major priority, the arbiter picks one winner. The winner's number and major priority go into a status register, and a request line to the processor is raised.

Top module: `vec_intc`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `irq_id_o` is zero.
- R2: Source n has its pending flag in bit n%32 of the word at 0x040 + 0x10*(n/32), and its enable bit in bit n%32 of the word at 0x0C0 + 0x10*(n/32).
- R3: The control, flag, enable and priority words answer at three addresses. A write to the base address replaces the word. A write to base+0x4 clears only the bits written as 1. A write to base+0x8 sets only the bits written as 1. A read of the base address returns the current value.
- R4: Source n has a 5-bit priority in bits [8*(n%4)+4 : 8*(n%4)] of the word at 0x140 + 0x10*(n/4). Field bits [4:2] are the major level and [1:0] the sub level. The unused bits of each byte lane read as zero.
- R5: The winner is the enabled, pending source with the highest major level, then the highest sub level, then the lowest number. A source whose major level is 0 never wins.
- R6: One clock after the flag, enable and priority state changes, `irq_o` is high exactly when a winner exists. The status word at 0x020 then holds the winner's number in bits [7:0] and its major level in bits [10:8], and `irq_id_o` equals the winner's number. With no winner, the status word and `irq_id_o` are zero.
- R7: A persistent source (a bit set in `LEVEL_MASK`; sources 48 to 63 by default) has its flag set two clocks after its input goes high. While the input stays high, a clear of that flag has no effect. After the input goes low, the flag stays set until software clears it.
- R8: A non-persistent source above the external range sets its flag two clocks after a rising edge on its input. A steady high level or a falling edge does not set the flag again.
- R9: Sources 0 to `NUM_EXT`-1 are external pins. Bit i of the control word at 0x000 selects the active edge of pin i: 1 for rising, 0 for falling. Only the selected edge sets the flag.
- R10: Source n has a 32-bit vector offset word at 0x540 + 4*n that reads back what was written. This array has no alias addresses, so a write to 0x544 changes only source 1's word.
- R11: When a captured input event and a software clear reach the same flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| src_i | input | NUM_SRC | Raw source inputs |
| irq_o | output | 1 | Request to the processor |
| irq_id_o | output | 8 | Number of the current winner |

## Verification
The bench first writes random enable, priority and flag patterns and compares each resulting winner with an independent software model. A tie-break that favoured the higher number, or an arbiter that let a major-0 source win, would report the wrong source number. Directed cases follow:
- A persistent flag is cleared while its input is still high. A design that honoured that clear would show the flag dropping.
- An event source is cleared while its input is held high. A design that treated the level as the event would set the flag again.
- An external pin is exercised under each polarity. A design with the polarity inverted would flag on the wrong edge.
- A clear is timed onto the same clock as a captured edge. A design that let software win that race would lose the event.
- Offset words are written at 4-byte spacing. A design that applied aliases to that array would corrupt the neighbouring source's word.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SET   = 2'd2,
        OP_RSVD  = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_STATUS,
        RK_FLAG,
        RK_ENABLE,
        RK_PRIO,
        RK_VECOFF
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        alias_op_e op;
        logic [7:0] idx;
    } reg_hit_t;

    localparam int SLOT_CTRL   = 'h00;
    localparam int SLOT_STATUS = 'h02;
    localparam int SLOT_FLAG   = 'h04;
    localparam int SLOT_ENABLE = 'h0C;
    localparam int SLOT_PRIO   = 'h14;
    localparam int ADDR_VECOFF = 'h540;
    localparam int PRIO_W      = 5;
    localparam int ID_W        = 8;

    function automatic logic apply_bit(input logic old_v, input logic wr_v, input alias_op_e op);
        case (op)
            OP_WRITE: return wr_v;
            OP_CLEAR: return old_v & ~wr_v;
            OP_SET:   return old_v | wr_v;
            default:  return old_v;
        endcase
    endfunction

endpackage

// File: rtl/vec_intc_decode.sv
module vec_intc_decode
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic        sel,
    input  logic [11:0] addr,
    output reg_hit_t    hit
);
    localparam int NBITREG  = (NUM_SRC + 31) / 32;
    localparam int NPRIOREG = (NUM_SRC + 3) / 4;

    int slot;
    int rel;

    always_comb begin
        hit.kind = RK_NONE;
        hit.op   = alias_op_e'(addr[3:2]);
        hit.idx  = '0;
        slot     = int'(addr[11:4]);
        rel      = int'(addr) - ADDR_VECOFF;
        if (sel) begin
            if (rel >= 0 && rel < 4 * NUM_SRC) begin
                hit.kind = RK_VECOFF;
                hit.op   = OP_WRITE;
                hit.idx  = 8'(rel >> 2);
            end else if (hit.op == OP_RSVD) begin
                hit.kind = RK_NONE;
            end else if (slot == SLOT_CTRL) begin
                hit.kind = RK_CTRL;
            end else if (slot == SLOT_STATUS) begin
                hit.kind = RK_STATUS;
            end else if (slot >= SLOT_FLAG && slot < SLOT_FLAG + NBITREG) begin
                hit.kind = RK_FLAG;
                hit.idx  = 8'(slot - SLOT_FLAG);
            end else if (slot >= SLOT_ENABLE && slot < SLOT_ENABLE + NBITREG) begin
                hit.kind = RK_ENABLE;
                hit.idx  = 8'(slot - SLOT_ENABLE);
            end else if (slot >= SLOT_PRIO && slot < SLOT_PRIO + NPRIOREG) begin
                hit.kind = RK_PRIO;
                hit.idx  = 8'(slot - SLOT_PRIO);
            end
        end
    end

endmodule

// File: rtl/vec_intc_capture.sv
module vec_intc_capture #(
    parameter int                   NUM_SRC    = 64,
    parameter int                   NUM_EXT    = 8,
    parameter logic [NUM_SRC-1:0]   LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_EXT-1:0] rise_sel,
    output logic [NUM_SRC-1:0] hw_set
);
    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.s1 = src_i;
        cap_d.s2 = cap_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g < NUM_EXT) begin : g_ext
            assign hw_set[g] = rise_sel[g] ? (cap_q.s1[g] & ~cap_q.s2[g])
                                           : (~cap_q.s1[g] & cap_q.s2[g]);
        end else if (LEVEL_MASK[g]) begin : g_lvl
            assign hw_set[g] = cap_q.s1[g];
        end else begin : g_edge
            assign hw_set[g] = cap_q.s1[g] & ~cap_q.s2[g];
        end
    end

endmodule

// File: rtl/vec_intc_arbiter.sv
module vec_intc_arbiter
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                           win_valid,
    output logic [ID_W-1:0]                win_id,
    output logic [PRIO_W-1:0]              win_prio
);
    localparam int LEAVES = 1 << $clog2(NUM_SRC);
    localparam int NODES  = 2 * LEAVES - 1;

    logic              nv [NODES];
    logic [PRIO_W-1:0] np [NODES];
    logic [ID_W-1:0]   ni [NODES];

    always_comb begin
        for (int l = 0; l < LEAVES; l++) begin
            if (l < NUM_SRC) begin
                nv[LEAVES-1+l] = req_i[l] && (prio_i[l][PRIO_W-1:2] != '0);
                np[LEAVES-1+l] = prio_i[l];
            end else begin
                nv[LEAVES-1+l] = 1'b0;
                np[LEAVES-1+l] = '0;
            end
            ni[LEAVES-1+l] = ID_W'(l);
        end
        for (int j = LEAVES - 2; j >= 0; j--) begin
            if (nv[2*j+2] && (!nv[2*j+1] || np[2*j+2] > np[2*j+1])) begin
                nv[j] = nv[2*j+2];
                np[j] = np[2*j+2];
                ni[j] = ni[2*j+2];
            end else begin
                nv[j] = nv[2*j+1];
                np[j] = np[2*j+1];
                ni[j] = ni[2*j+1];
            end
        end
        win_valid = nv[0];
        win_id    = nv[0] ? ni[0] : '0;
        win_prio  = nv[0] ? np[0] : '0;
    end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int                 NUM_SRC    = 64,
    parameter int                 NUM_EXT    = 8,
    parameter int                 OFF_W      = 32,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = ~({NUM_SRC{1'b1}} >> (NUM_SRC / 4))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    output logic [7:0]         irq_id_o
);
    typedef struct packed {
        logic [NUM_EXT-1:0]             pol;
        logic [NUM_SRC-1:0]             flag;
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_SRC-1:0][OFF_W-1:0]  voff;
        logic                           irq;
        logic [ID_W-1:0]                id;
        logic [2:0]                     major;
    } state_t;

    state_t st_d, st_q;

    reg_hit_t          hit;
    logic [NUM_SRC-1:0] hw_set;
    logic              win_valid;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic              wr;

    logic [NUM_SRC-1:0] flag_vis;
    logic [NUM_SRC-1:0] en_vis;
    logic [2:0]         major_vis;

    vec_intc_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .sel  (bus_sel),
        .addr (bus_addr),
        .hit  (hit)
    );

    vec_intc_capture #(
        .NUM_SRC    (NUM_SRC),
        .NUM_EXT    (NUM_EXT),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .rise_sel (st_q.pol),
        .hw_set   (hw_set)
    );

    vec_intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .req_i     (st_q.flag & st_q.en),
        .prio_i    (st_q.prio),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    // next-state computation
    always_comb begin
        st_d = st_q;
        wr   = bus_sel & bus_we;

        for (int i = 0; i < NUM_EXT; i++) begin
            if (wr && hit.kind == RK_CTRL)
                st_d.pol[i] = apply_bit(st_q.pol[i], bus_wdata[i], hit.op);
        end

        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr && hit.kind == RK_FLAG && int'(hit.idx) == i / 32)
                st_d.flag[i] = apply_bit(st_q.flag[i], bus_wdata[i % 32], hit.op);
            // a captured event outranks any software clear in the same cycle
            st_d.flag[i] = st_d.flag[i] | hw_set[i];

            if (wr && hit.kind == RK_ENABLE && int'(hit.idx) == i / 32)
                st_d.en[i] = apply_bit(st_q.en[i], bus_wdata[i % 32], hit.op);

            if (wr && hit.kind == RK_PRIO && int'(hit.idx) == i / 4) begin
                for (int b = 0; b < PRIO_W; b++)
                    st_d.prio[i][b] = apply_bit(st_q.prio[i][b],
                                                bus_wdata[8 * (i % 4) + b], hit.op);
            end

            if (wr && hit.kind == RK_VECOFF && int'(hit.idx) == i)
                st_d.voff[i] = bus_wdata[OFF_W-1:0];
        end

        st_d.irq   = win_valid;
        st_d.id    = win_id;
        st_d.major = win_prio[PRIO_W-1:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path: aliases read as zero
    always_comb begin
        bus_rdata = '0;
        if (hit.op == OP_WRITE) begin
            case (hit.kind)
                RK_CTRL: bus_rdata[NUM_EXT-1:0] = st_q.pol;
                RK_STATUS: begin
                    bus_rdata[7:0]  = st_q.id;
                    bus_rdata[10:8] = st_q.major;
                end
                RK_FLAG: begin
                    for (int i = 0; i < NUM_SRC; i++)
                        if (int'(hit.idx) == i / 32) bus_rdata[i % 32] = st_q.flag[i];
                end
                RK_ENABLE: begin
                    for (int i = 0; i < NUM_SRC; i++)
                        if (int'(hit.idx) == i / 32) bus_rdata[i % 32] = st_q.en[i];
                end
                RK_PRIO: begin
                    for (int i = 0; i < NUM_SRC; i++)
                        if (int'(hit.idx) == i / 4)
                            bus_rdata[8 * (i % 4) +: PRIO_W] = st_q.prio[i];
                end
                RK_VECOFF: begin
                    for (int i = 0; i < NUM_SRC; i++)
                        if (int'(hit.idx) == i) bus_rdata[OFF_W-1:0] = st_q.voff[i];
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_o     = st_q.irq;
    assign irq_id_o  = st_q.id;
    assign flag_vis  = st_q.flag;
    assign en_vis    = st_q.en;
    assign major_vis = st_q.major;

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
    parameter int                 NUM_SRC    = 64,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] hw_set,
    input logic               irq_o,
    input logic [7:0]         irq_id_o,
    input logic [2:0]         major
);
    localparam int IDXW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= flag_q & en_q;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o); // R1

    AST_PERSIST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        |(hw_set & LEVEL_MASK) |=> ((flag_q & $past(hw_set & LEVEL_MASK)) == $past(hw_set & LEVEL_MASK))); // R7

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        |(hw_set & ~LEVEL_MASK) |=> ((flag_q & $past(hw_set & ~LEVEL_MASK)) == $past(hw_set & ~LEVEL_MASK))); // R11

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_q[irq_id_o[IDXW-1:0]]); // R5

    AST_WINNER_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (major != 3'd0 && int'(irq_id_o) < NUM_SRC)); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_id_o == 8'd0 && major == 3'd0)); // R6

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !irq_o); // R6

endmodule

bind vec_intc vec_intc_chk #(
    .NUM_SRC    (NUM_SRC),
    .LEVEL_MASK (LEVEL_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_q   (flag_vis),
    .en_q     (en_vis),
    .hw_set   (hw_set),
    .irq_o    (irq_o),
    .irq_id_o (irq_id_o),
    .major    (major_vis)
);

// File: tb/vec_intc_test.sv
`timescale 1ns/1ps
module vec_intc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src = '0;
    logic        irq_o;
    logic [7:0]  irq_id_o;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_fl = '0;
    logic [63:0] m_en = '0;
    logic [4:0]  m_pr [64];

    always #4 clk = ~clk;

    vec_intc uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_i(src), .irq_o(irq_o), .irq_id_o(irq_id_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_id();
        int best = -1;
        for (int i = 0; i < 64; i++)
            if (m_fl[i] && m_en[i] && m_pr[i][4:2] != 3'd0)
                if (best < 0 || m_pr[i] > m_pr[best]) best = i;
        return best;
    endfunction

    task automatic clear_all();
        for (int k = 0; k < 2; k++) begin
            bus_wr(12'h040 + 12'(16 * k), 32'h0);
            bus_wr(12'h0C0 + 12'(16 * k), 32'h0);
        end
        for (int k = 0; k < 16; k++) bus_wr(12'h140 + 12'(16 * k), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] w;
        int eid;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) m_pr[i] = '0;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1: reset state
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
        chk("R1 irq_id_o", {24'b0, irq_id_o}, 32'h0);
        bus_rd(12'h000, d); chk("R1 ctrl", d, 32'h0);
        bus_rd(12'h020, d); chk("R1 status", d, 32'h0);
        bus_rd(12'h050, d); chk("R1 flag1", d, 32'h0);
        bus_rd(12'h0C0, d); chk("R1 enable0", d, 32'h0);
        bus_rd(12'h140, d); chk("R1 prio0", d, 32'h0);
        bus_rd(12'h63C, d); chk("R1 offset63", d, 32'h0);

        // R5 R6: random configurations against a model
        for (int it = 0; it < 30; it++) begin
            for (int k = 0; k < 2; k++) begin
                w = $urandom; bus_wr(12'h0C0 + 12'(16 * k), w); m_en[32*k +: 32] = w;
            end
            for (int k = 0; k < 16; k++) begin
                w = $urandom; bus_wr(12'h140 + 12'(16 * k), w);
                for (int l = 0; l < 4; l++) m_pr[4*k+l] = w[8*l +: 5];
            end
            for (int k = 0; k < 2; k++) begin
                w = $urandom; bus_wr(12'h048 + 12'(16 * k), w); m_fl[32*k +: 32] |= w;
                w = $urandom; bus_wr(12'h044 + 12'(16 * k), w); m_fl[32*k +: 32] &= ~w;
            end
            settle(1);
            eid = exp_id();
            bus_rd(12'h020, d);
            if (eid < 0) begin
                chk("R6 random irq", {31'b0, irq_o}, 32'h0);
                chk("R6 random status", d, 32'h0);
            end else begin
                chk("R6 random irq", {31'b0, irq_o}, 32'h1);
                chk("R5 random winner", {24'b0, irq_id_o}, 32'(eid));
                chk("R6 random status", d, {21'b0, m_pr[eid][4:2], 8'(eid)});
            end
        end
        clear_all();
        settle(1);
        chk("R6 idle after clear", {31'b0, irq_o}, 32'h0);

        // R2: bit placement
        bus_wr(12'h0D8, 32'h20);
        bus_rd(12'h0D0, d); chk("R2 enable source 37", d, 32'h20);
        bus_wr(12'h058, 32'h20);
        bus_rd(12'h050, d); chk("R2 flag source 37", d, 32'h20);
        bus_wr(12'h1D0, 32'h0000_1400);
        settle(1);
        bus_rd(12'h020, d); chk("R6 status source 37 major 5", d, 32'h0000_0525);
        chk("R6 irq_id_o 37", {23'b0, irq_o, irq_id_o}, 32'h125);

        // R5: sub level, ties, major 0
        bus_wr(12'h0D8, 32'h50); bus_wr(12'h058, 32'h50);
        bus_wr(12'h1D8, 32'h0015_0015);
        settle(1);
        chk("R5 sub level and tie pick 36", {24'b0, irq_id_o}, 32'd36);
        bus_wr(12'h1D0, 32'h0303_0303);
        settle(1);
        chk("R5 major 0 never wins", {31'b0, irq_o}, 32'h0);
        bus_rd(12'h020, d); chk("R6 status idle", d, 32'h0);

        // R4: lane packing
        bus_wr(12'h140, 32'hFFFF_FFFF);
        bus_rd(12'h140, d); chk("R4 lane width", d, 32'h1F1F_1F1F);
        bus_wr(12'h144, 32'h00FF_0000);
        bus_rd(12'h140, d); chk("R4 clear lane 2", d, 32'h1F00_1F1F);
        bus_wr(12'h140, 32'h0);

        // R3: aliases
        bus_wr(12'h0C0, 32'hA5A5_A5A5);
        bus_wr(12'h0C4, 32'h0000_000F);
        bus_rd(12'h0C0, d); chk("R3 clear alias", d, 32'hA5A5_A5A0);
        bus_wr(12'h0C8, 32'h0000_0F00);
        bus_rd(12'h0C0, d); chk("R3 set alias", d, 32'hA5A5_AFA0);
        clear_all();

        // R7: persistent source 50
        @(negedge clk); src[50] = 1'b1;
        settle(3);
        bus_rd(12'h050, d); chk("R7 level sets flag", d, 32'h0004_0000);
        bus_wr(12'h054, 32'h0004_0000);
        settle(2);
        bus_rd(12'h050, d); chk("R7 clear ignored while high", d, 32'h0004_0000);
        src[50] = 1'b0;
        settle(3);
        bus_rd(12'h050, d); chk("R7 flag held after release", d, 32'h0004_0000);
        bus_wr(12'h054, 32'h0004_0000);
        bus_rd(12'h050, d); chk("R7 clear after release", d, 32'h0);

        // R8: event source 20
        @(negedge clk); src[20] = 1'b1;
        settle(3);
        bus_rd(12'h040, d); chk("R8 rising edge sets", d, 32'h0010_0000);
        bus_wr(12'h044, 32'h0010_0000);
        settle(3);
        bus_rd(12'h040, d); chk("R8 steady level does not reset flag", d, 32'h0);
        src[20] = 1'b0;
        settle(3);
        bus_rd(12'h040, d); chk("R8 falling edge ignored", d, 32'h0);

        // R11: event and clear in the same clock
        @(negedge clk); src[21] = 1'b1;
        bus_wr(12'h044, 32'h0020_0000);
        bus_rd(12'h040, d); chk("R11 event beats clear", d, 32'h0020_0000);
        src[21] = 1'b0;
        bus_wr(12'h044, 32'h0020_0000);

        // R9: external polarity on pin 2
        @(negedge clk); src[2] = 1'b1;
        settle(3);
        bus_rd(12'h040, d); chk("R9 falling mode ignores rise", d, 32'h0);
        src[2] = 1'b0;
        settle(3);
        bus_rd(12'h040, d); chk("R9 falling mode sets", d, 32'h4);
        bus_wr(12'h044, 32'h4);
        bus_wr(12'h008, 32'h4);
        bus_rd(12'h000, d); chk("R9 ctrl polarity readback", d, 32'h4);
        @(negedge clk); src[2] = 1'b1;
        settle(3);
        bus_rd(12'h040, d); chk("R9 rising mode sets", d, 32'h4);

        // R10: offset array
        bus_wr(12'h63C, 32'hDEAD_BEEF);
        bus_wr(12'h540, 32'h1234_5678);
        bus_wr(12'h544, 32'h0000_00FF);
        bus_rd(12'h63C, d); chk("R10 offset 63", d, 32'hDEAD_BEEF);
        bus_rd(12'h540, d); chk("R10 offset 0 untouched by 0x544", d, 32'h1234_5678);
        bus_rd(12'h544, d); chk("R10 offset 1", d, 32'h0000_00FF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule